// File: doc/BRIEF.md
# Accumulator Processor Core

A compact multicycle processor built around one 8-bit accumulator and a four-entry register file. Instruction bytes come from a 256-byte internal program memory. Data lives in a separate 16-byte data memory. The controller, datapath and both memories sit inside one block. Ordinary instructions take one byte. The two jump forms take two bytes: an opcode byte followed by the absolute target address.

A testbench or loader holds reset high and writes the program through a byte-wide write port. It then releases reset and watches the accumulator, the program counter and the halted flag. Reset clears the PC, the accumulator, the registers and the data memory. It leaves program memory untouched, so a loaded program survives reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and in the cycle after it, the accumulator and PC read 0 and halted reads 0. After reset, every register and every data memory byte reads 0.
- R2: LOADI (opcode 0011 in bits 7:4) writes its 4-bit immediate from bits 3:0 to the accumulator, zero-extended to 8 bits.
- R3: MOVR (0001) copies the accumulator into the register selected by bits 3:2. MOVA (0000) copies the selected register into the accumulator.
- R4: STORE (0100) writes the accumulator to data address bits 3:0. LOAD (0010) reads that address into the accumulator. Program memory keeps its contents through reset.
- R5: ADD (0111) and SUB (1000) add or subtract the selected register, wrapping modulo 256.
- R6: ANDR (1001) ANDs the selected register into the accumulator bit by bit. INV (1011) complements the accumulator.
- R7: SHR (1010) shifts the accumulator right by one and fills bit 7 with 0.
- R8: JMP (byte 0110_0000 followed by a target byte) loads the target into the PC.
- R9: JZ (byte 0101_0000 followed by a target byte) loads the target only when the accumulator is 0. Otherwise the PC continues past both bytes.
- R10: The byte 1111_1111 halts the core. The halted flag then stays 1, and the PC (HALT address + 1) and the accumulator stay constant until reset.
- R11: Opcodes 1100, 1101 and 1110, and 1111 with a nonzero low nibble, are one-byte no-operations.
- R12: From the release of reset, a one-byte instruction takes 3 clock cycles and a jump takes 4. HALT raises the flag 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 8 | Program memory write address |
| prog_wdata | input | 8 | Program memory write data |
| acc_out | output | 8 | Accumulator value |
| pc_out | output | 8 | Program counter |
| halted | output | 1 | Core has executed HALT |

## Verification
The registers and the data memory have no port of their own, so their contents can only be seen through a short program. The program moves the value of interest into the accumulator and then halts. Checking that data memory is cleared needs a STORE in one run, then a reset, then a LOAD in a second run that reuses the preserved program memory. The jump-not-taken path is confirmed from the PC value at HALT, which shows that both jump bytes were skipped.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

    localparam int DATA_W   = 8;
    localparam int PC_W     = 8;
    localparam int DADDR_W  = 4;
    localparam int NUM_REGS = 4;
    localparam logic [7:0] HALT_BYTE = 8'hFF;

    typedef enum logic [3:0] {
        OP_MOVA  = 4'b0000,
        OP_MOVR  = 4'b0001,
        OP_LOAD  = 4'b0010,
        OP_LOADI = 4'b0011,
        OP_STORE = 4'b0100,
        OP_JZ    = 4'b0101,
        OP_JMP   = 4'b0110,
        OP_ADD   = 4'b0111,
        OP_SUB   = 4'b1000,
        OP_ANDR  = 4'b1001,
        OP_SHR   = 4'b1010,
        OP_INV   = 4'b1011
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_ADDR,
        ST_EXEC,
        ST_HALT
    } state_e;

    function automatic logic is_jump(input logic [3:0] op);
        return (op == OP_JZ) || (op == OP_JMP);
    endfunction

    function automatic logic uses_alu(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ANDR) ||
               (op == OP_SHR) || (op == OP_INV);
    endfunction

endpackage

// File: rtl/acc_cpu_regfile.sv
`timescale 1ns/1ps
module acc_cpu_regfile #(
    parameter int W     = 8,
    parameter int NREG  = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SELW-1:0] sel,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    rd_data
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[sel] <= wr_data;
        end
    end

    assign rd_data = regs[sel];

endmodule

// File: rtl/acc_cpu_alu.sv
`timescale 1ns/1ps
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_ANDR: y = a & b;
            OP_INV:  y = ~a;
            OP_SHR:  y = {1'b0, a[W-1:1]};
            default: y = a;
        endcase
    end

endmodule

// File: rtl/acc_cpu_core.sv
`timescale 1ns/1ps
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int PW   = PC_W,
    parameter int DAW  = DADDR_W,
    parameter int NREG = NUM_REGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_we,
    input  logic [PW-1:0] prog_addr,
    input  logic [7:0]    prog_wdata,
    output logic [DW-1:0] acc_out,
    output logic [PW-1:0] pc_out,
    output logic          halted
);

    localparam int PDEPTH = 1 << PW;
    localparam int DDEPTH = 1 << DAW;
    localparam int SELW   = $clog2(NREG);

    logic [7:0]    pmem [PDEPTH];
    logic [DW-1:0] dmem [DDEPTH];

    state_e        st;
    logic [7:0]    ir;
    logic [PW-1:0] tgt;
    logic [PW-1:0] pc;
    logic [DW-1:0] acc;

    logic [3:0]     op;
    logic [SELW-1:0] rsel;
    logic [DAW-1:0]  daddr;
    logic [DW-1:0]   rf_rd;
    logic [DW-1:0]   alu_y;
    logic            rf_we;

    assign op    = ir[7:4];
    assign rsel  = ir[3:2];
    assign daddr = ir[DAW-1:0];
    assign rf_we = (st == ST_EXEC) && (op == OP_MOVR);

    // Program store: untouched by reset so a preloaded program survives it.
    always_ff @(posedge clk) begin
        if (prog_we) pmem[prog_addr] <= prog_wdata;
    end

    acc_cpu_regfile #(.W(DW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_we),
        .sel     (rsel),
        .wr_data (acc),
        .rd_data (rf_rd)
    );

    acc_cpu_alu #(.W(DW)) u_alu (
        .op (op),
        .a  (acc),
        .b  (rf_rd),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_FETCH;
            ir  <= '0;
            tgt <= '0;
            pc  <= '0;
            acc <= '0;
            for (int i = 0; i < DDEPTH; i++) dmem[i] <= '0;
        end else begin
            unique case (st)
                ST_FETCH: begin
                    ir <= pmem[pc];
                    pc <= pc + 1'b1;
                    st <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (ir == HALT_BYTE)  st <= ST_HALT;
                    else if (is_jump(op)) st <= ST_ADDR;
                    else                  st <= ST_EXEC;
                end
                ST_ADDR: begin
                    tgt <= pmem[pc];
                    pc  <= pc + 1'b1;
                    st  <= ST_EXEC;
                end
                ST_EXEC: begin
                    st <= ST_FETCH;
                    if (uses_alu(op)) begin
                        acc <= alu_y;
                    end else begin
                        case (op)
                            OP_MOVA:  acc <= rf_rd;
                            OP_LOAD:  acc <= dmem[daddr];
                            OP_LOADI: acc <= DW'(ir[3:0]);
                            OP_STORE: dmem[daddr] <= acc;
                            OP_JMP:   pc <= tgt;
                            OP_JZ:    if (acc == '0) pc <= tgt;
                            default:  ;
                        endcase
                    end
                end
                ST_HALT: st <= ST_HALT;
                default: st <= ST_FETCH;
            endcase
        end
    end

    assign acc_out = acc;
    assign pc_out  = pc;
    assign halted  = (st == ST_HALT);

endmodule

// File: rtl/acc_cpu_core_chk.sv
`timescale 1ns/1ps
module acc_cpu_core_chk
    import acc_cpu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       halted,
    input logic [7:0] pc_out,
    input logic [7:0] acc_out,
    input state_e     st,
    input logic [7:0] ir,
    input logic [7:0] tgt
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_out == 8'h00 && acc_out == 8'h00 && !halted));

    assert_jmp_target_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXEC && ir == 8'h60) |=> (pc_out == $past(tgt)));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_out) && $stable(acc_out)));

    assert_halt_decode_R10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DECODE && ir == 8'hFF) |=> halted);

    assert_fetch_then_decode_R12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH) |=> (st == ST_DECODE));

    assert_acc_only_in_exec_R12: assert property (@(posedge clk) disable iff (rst)
        (st != ST_EXEC) |=> $stable(acc_out));

endmodule

bind acc_cpu_core acc_cpu_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .halted  (halted),
    .pc_out  (pc_out),
    .acc_out (acc_out),
    .st      (st),
    .ir      (ir),
    .tgt     (tgt)
);

// File: tb/acc_cpu_core_test.sv
`timescale 1ns/1ps
module acc_cpu_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [7:0] prog_addr = '0;
    logic [7:0] prog_wdata = '0;
    logic [7:0] acc_out;
    logic [7:0] pc_out;
    logic       halted;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    acc_cpu_core uut (
        .clk        (clk),
        .rst        (rst),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_wdata (prog_wdata),
        .acc_out    (acc_out),
        .pc_out     (pc_out),
        .halted     (halted)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        prog_we = 1'b1; prog_addr = a; prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic go(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && cyc < 500) begin
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic t_reset();
        int c;
        hold_reset();
        chk("R1 acc in reset", acc_out, 0);
        chk("R1 pc in reset", pc_out, 0);
        chk("R1 halted in reset", halted, 0);
        wr(0, 8'h37); wr(1, 8'h78); wr(2, 8'h7C); wr(3, 8'hFF);
        go(c);
        chk("R1 registers cleared", acc_out, 8'h07);
    endtask

    task automatic t_loadi();
        int c;
        hold_reset();
        wr(0, 8'h3F); wr(1, 8'hFF);
        go(c);
        chk("R2 LOADI zero-extend", acc_out, 8'h0F);
        chk("R12 one-byte + HALT cycles", c, 5);
    endtask

    task automatic t_regs();
        int c;
        hold_reset();
        wr(0, 8'h33); wr(1, 8'h14); wr(2, 8'h3A); wr(3, 8'h1C);
        wr(4, 8'h30); wr(5, 8'h04); wr(6, 8'h7C); wr(7, 8'hFF);
        go(c);
        chk("R3 MOVR/MOVA select", acc_out, 8'h0D);
    endtask

    task automatic t_mem();
        int c;
        hold_reset();
        wr(0, 8'h39); wr(1, 8'h45); wr(2, 8'h30); wr(3, 8'h25); wr(4, 8'hFF);
        go(c);
        chk("R4 STORE then LOAD", acc_out, 8'h09);
        hold_reset();
        go(c);
        chk("R4 program kept through reset", acc_out, 8'h09);
        hold_reset();
        wr(0, 8'h25); wr(1, 8'hFF);
        go(c);
        chk("R1 data memory cleared", acc_out, 8'h00);
    endtask

    task automatic t_arith();
        int c;
        hold_reset();
        wr(0, 8'h32); wr(1, 8'h10); wr(2, 8'h31); wr(3, 8'h80); wr(4, 8'hFF);
        go(c);
        chk("R5 SUB wraps below zero", acc_out, 8'hFF);
        hold_reset();
        wr(4, 8'h70); wr(5, 8'hFF);
        go(c);
        chk("R5 ADD wraps above 255", acc_out, 8'h01);
    endtask

    task automatic t_logic();
        int c;
        hold_reset();
        wr(0, 8'h3C); wr(1, 8'h10); wr(2, 8'h3A); wr(3, 8'h90); wr(4, 8'hFF);
        go(c);
        chk("R6 ANDR", acc_out, 8'h08);
        hold_reset();
        wr(4, 8'hB0); wr(5, 8'hFF);
        go(c);
        chk("R6 INV", acc_out, 8'hF7);
    endtask

    task automatic t_shr();
        int c;
        hold_reset();
        wr(0, 8'h3F); wr(1, 8'hB0); wr(2, 8'hA0); wr(3, 8'hFF);
        go(c);
        chk("R7 SHR zero fill", acc_out, 8'h78);
        hold_reset();
        wr(0, 8'h31); wr(1, 8'hA0); wr(2, 8'hFF);
        go(c);
        chk("R7 SHR of one", acc_out, 8'h00);
    endtask

    task automatic t_jmp();
        int c;
        hold_reset();
        wr(0, 8'h60); wr(1, 8'h05); wr(2, 8'h31); wr(3, 8'hFF);
        wr(4, 8'h00); wr(5, 8'h35); wr(6, 8'hFF);
        go(c);
        chk("R8 JMP target acc", acc_out, 8'h05);
        chk("R8 JMP pc at halt", pc_out, 8'h07);
        chk("R12 jump cycles", c, 9);
    endtask

    task automatic t_jz();
        int c;
        hold_reset();
        wr(0, 8'h30); wr(1, 8'h50); wr(2, 8'h05); wr(3, 8'h31);
        wr(4, 8'hFF); wr(5, 8'h37); wr(6, 8'hFF);
        go(c);
        chk("R9 JZ taken acc", acc_out, 8'h07);
        chk("R9 JZ taken pc", pc_out, 8'h07);
        hold_reset();
        wr(0, 8'h31); wr(1, 8'h50); wr(2, 8'h06); wr(3, 8'h32); wr(4, 8'hFF);
        go(c);
        chk("R9 JZ not taken acc", acc_out, 8'h02);
        chk("R9 JZ not taken pc", pc_out, 8'h05);
    endtask

    task automatic t_undef();
        int c;
        hold_reset();
        wr(0, 8'h35); wr(1, 8'hC0); wr(2, 8'hD3); wr(3, 8'hE7);
        wr(4, 8'hF1); wr(5, 8'hFF);
        go(c);
        chk("R11 undefined acc", acc_out, 8'h05);
        chk("R11 undefined pc", pc_out, 8'h06);
        chk("R11 undefined cycles", c, 17);
    endtask

    task automatic t_halt();
        int c;
        hold_reset();
        wr(0, 8'h34); wr(1, 8'hFF); wr(2, 8'h31); wr(3, 8'hFF);
        go(c);
        repeat (10) @(negedge clk);
        chk("R10 halted stays", halted, 1);
        chk("R10 pc frozen", pc_out, 8'h02);
        chk("R10 acc frozen", acc_out, 8'h04);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_loadi();
        t_regs();
        t_mem();
        t_arith();
        t_logic();
        t_shr();
        t_jmp();
        t_jz();
        t_undef();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule